// File: doc/BRIEF.md
# Power Mode Clock Controller

This block decides, cycle by cycle, whether the CPU and the peripherals of a small microcontroller receive a clock, and whether the main oscillator and the auxiliary RC oscillator run. It offers a full-speed run state, a slow-down option that divides the effective clock rate by a parameter (eight by default), an idle state that stops only the CPU, and a software power-down state that stops both oscillators while RAM keeps its contents. A dedicated hardware power-down pin overrides every other state, stops both oscillators and floats the port pins.

A protect input gates every software-requested mode. While it is high, requests for slow-down, idle or power-down are dropped and the device keeps running unchanged. It is high when left open. Its level during reset is latched once and drives a watchdog auto-start flag. Later changes of the pin do not alter that flag. Idle and power-down need an arming write immediately followed by the mode write. Any other register write in between cancels the arming.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (run), both clock enables are high every cycle, both oscillator enables are high and port_float_o is low. The mode codes are 0 run, 1 idle, 2 power-down and 3 hardware power-down.
- R2: wdt_auto_o takes the level prot_i had during reset at the first clock edge after reset release. It then holds that value until the next reset, whatever prot_i does.
- R3: With prot_i low, a slow write with slow_val_i high makes cpu_clk_en_o and per_clk_en_o high in exactly one cycle out of every DIV cycles. A slow write with slow_val_i low restores enables in every cycle.
- R4: With prot_i low, an arm write followed by an idle write gives mode 1 in the next cycle. In mode 1 cpu_clk_en_o is low, while per_clk_en_o and both oscillator enables stay high.
- R5: In mode 1, a cycle with irq_i high returns the block to mode 0 at the next clock edge.
- R6: With prot_i low, an arm write followed by a power-down write gives mode 2. In mode 2 all clock and oscillator enables are low, irq_i has no effect, and only rst_ni or hw_pd_i leaves the mode.
- R7: An idle or power-down write counts only when the write just before it was an arm write. A slow write or any other write in between cancels the arming, and an unarmed mode write leaves mode 0 unchanged.
- R8: While prot_i is high, slow, idle and power-down requests have no effect, and the block stays in mode 0 at full rate.
- R9: hw_pd_i high gives mode 3 at the next edge from any state and at any prot_i level. In mode 3 port_float_o is high and all enables are low. When the pin is released, the block returns to mode 0 with the slow option and the arming cleared, and wdt_auto_o is unchanged.
- R10: When hw_pd_i rises in the same cycle as an armed mode write, hardware power-down wins and the block enters mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prot_i | input | 1 | Protect pin, high blocks software power modes (pulled high externally) |
| hw_pd_i | input | 1 | Hardware power-down pin, active high |
| wr_arm_i | input | 1 | Write strobe for the arming bit |
| wr_idle_i | input | 1 | Write strobe for the idle request bit |
| wr_pdn_i | input | 1 | Write strobe for the power-down request bit |
| wr_slow_i | input | 1 | Write strobe for the slow-down bit |
| slow_val_i | input | 1 | Value written with wr_slow_i |
| wr_other_i | input | 1 | Any other register write |
| irq_i | input | 1 | Enabled interrupt pending, wakes idle |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| rc_osc_en_o | output | 1 | RC oscillator enable |
| port_float_o | output | 1 | Float port pins and control lines |
| wdt_auto_o | output | 1 | Watchdog auto-start flag latched at reset |
| mode_o | output | 2 | Current mode code |

## Verification
The collision of interest is a hardware power-down pin that rises in the same clock cycle in which an armed power-down write completes. In that case two different next states compete for one register. The bench arms the sequence, then raises wr_pdn_i and hw_pd_i together for one edge and expects mode 3 with floating ports, not mode 2. On release it expects a clean return to mode 0. A second overlap checked is a change of prot_i after reset, when a latch that is not truly one-shot would let the protect level leak into the watchdog flag.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PDN  = 2'd2,
    MODE_HWPD = 2'd3
  } pmode_e;
endpackage

// File: rtl/pwr_arm_seq.sv
module pwr_arm_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic wr_arm_i,
  input  logic wr_idle_i,
  input  logic wr_pdn_i,
  input  logic wr_slow_i,
  input  logic wr_other_i,
  output logic idle_req_o,
  output logic pdn_req_o
);
  logic armed_q;
  logic any_wr;

  assign any_wr = wr_arm_i | wr_idle_i | wr_pdn_i | wr_slow_i | wr_other_i;

  // arming survives idle cycles, any non-arm write consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (clr_i || !run_i)   armed_q <= 1'b0;
    else if (wr_arm_i)          armed_q <= 1'b1;
    else if (any_wr)            armed_q <= 1'b0;
  end

  assign idle_req_o = run_i & armed_q & wr_idle_i;
  assign pdn_req_o  = run_i & armed_q & wr_pdn_i;
endmodule

// File: rtl/pwr_slow_div.sv
module pwr_slow_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wr_i,
  input  logic val_i,
  input  logic allow_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic          slow_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 slow_q <= 1'b0;
    else if (clr_i)              slow_q <= 1'b0;
    else if (wr_i && !val_i)     slow_q <= 1'b0;
    else if (wr_i && allow_i)    slow_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!slow_q)         cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !slow_q || (cnt_q == LAST);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   hw_pd_i,
  input  logic   allow_i,
  input  logic   idle_req_i,
  input  logic   pdn_req_i,
  input  logic   wake_i,
  output pmode_e mode_o,
  output logic   soft_clr_o
);
  pmode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (hw_pd_i) begin
      mode_d = MODE_HWPD;
    end else begin
      unique case (mode_q)
        MODE_RUN: begin
          if (allow_i && pdn_req_i)       mode_d = MODE_PDN;
          else if (allow_i && idle_req_i) mode_d = MODE_IDLE;
        end
        MODE_IDLE: if (wake_i) mode_d = MODE_RUN;
        MODE_PDN:  mode_d = MODE_PDN;
        MODE_HWPD: mode_d = MODE_RUN;
        default:   mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  // pin release acts as an internal reset of the mode options
  assign soft_clr_o = (mode_q == MODE_HWPD) && !hw_pd_i;
  assign mode_o     = mode_q;
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prot_i,
  input  logic       hw_pd_i,
  input  logic       wr_arm_i,
  input  logic       wr_idle_i,
  input  logic       wr_pdn_i,
  input  logic       wr_slow_i,
  input  logic       slow_val_i,
  input  logic       wr_other_i,
  input  logic       irq_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_en_o,
  output logic       rc_osc_en_o,
  output logic       port_float_o,
  output logic       wdt_auto_o,
  output logic [1:0] mode_o
);
  pmode_e mode;
  logic   soft_clr, run, allow, tick;
  logic   idle_req, pdn_req;
  logic   wdt_q, wdt_done_q;

  assign run   = (mode == MODE_RUN);
  assign allow = !prot_i;

  pwr_arm_seq u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_clr),
    .run_i      (run),
    .wr_arm_i   (wr_arm_i),
    .wr_idle_i  (wr_idle_i),
    .wr_pdn_i   (wr_pdn_i),
    .wr_slow_i  (wr_slow_i),
    .wr_other_i (wr_other_i),
    .idle_req_o (idle_req),
    .pdn_req_o  (pdn_req)
  );

  pwr_slow_div #(.DIV(DIV)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_clr),
    .wr_i    (wr_slow_i & run),
    .val_i   (slow_val_i),
    .allow_i (allow),
    .tick_o  (tick)
  );

  pwr_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_pd_i    (hw_pd_i),
    .allow_i    (allow),
    .idle_req_i (idle_req),
    .pdn_req_i  (pdn_req),
    .wake_i     (irq_i),
    .mode_o     (mode),
    .soft_clr_o (soft_clr)
  );

  // one-shot capture of the protect level right after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q      <= 1'b0;
      wdt_done_q <= 1'b0;
    end else if (!wdt_done_q) begin
      wdt_q      <= prot_i;
      wdt_done_q <= 1'b1;
    end
  end

  assign cpu_clk_en_o = tick & run;
  assign per_clk_en_o = tick & (run | (mode == MODE_IDLE));
  assign osc_en_o     = run | (mode == MODE_IDLE);
  assign rc_osc_en_o  = (mode != MODE_PDN) && (mode != MODE_HWPD);
  assign port_float_o = (mode == MODE_HWPD);
  assign wdt_auto_o   = wdt_q;
  assign mode_o       = mode;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prot_i,
  input logic       hw_pd_i,
  input logic       irq_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       osc_en_o,
  input logic       rc_osc_en_o,
  input logic       port_float_o,
  input logic       wdt_auto_o,
  input logic [1:0] mode_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R2
  wdt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> $stable(wdt_auto_o));

  // R3
  cpu_needs_per_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> per_clk_en_o);

  // R4
  idle_cpu_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> (!cpu_clk_en_o && osc_en_o));

  // R6
  pdn_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && !hw_pd_i) |=> (mode_o == 2'd2));

  // R8
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_i && mode_o == 2'd0 && !hw_pd_i) |=> (mode_o == 2'd0));

  // R9
  hwpd_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_pd_i |=> (mode_o == 2'd3 && port_float_o));

  // R9
  float_osc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_float_o |-> (!osc_en_o && !rc_osc_en_o && !per_clk_en_o));
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prot_i       (prot_i),
  .hw_pd_i      (hw_pd_i),
  .irq_i        (irq_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .osc_en_o     (osc_en_o),
  .rc_osc_en_o  (rc_osc_en_o),
  .port_float_o (port_float_o),
  .wdt_auto_o   (wdt_auto_o),
  .mode_o       (mode_o)
);

// File: tb/pwr_clk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, prot, hw_pd, wr_arm, wr_idle, wr_pdn, wr_slow, slow_val, wr_other, irq;
  logic cpu, per, osc, rc, flt, wdt;
  logic [1:0] mode;

  pwr_clk_ctrl #(.DIV(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .prot_i(prot), .hw_pd_i(hw_pd),
    .wr_arm_i(wr_arm), .wr_idle_i(wr_idle), .wr_pdn_i(wr_pdn),
    .wr_slow_i(wr_slow), .slow_val_i(slow_val), .wr_other_i(wr_other),
    .irq_i(irq), .cpu_clk_en_o(cpu), .per_clk_en_o(per), .osc_en_o(osc),
    .rc_osc_en_o(rc), .port_float_o(flt), .wdt_auto_o(wdt), .mode_o(mode)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { string req; logic [7:0] v; } exp_t;
  exp_t sb_q[$];

  function automatic logic [7:0] ev(logic c, logic p, logic o, logic f, logic w, logic [1:0] m);
    return {c, p, o, o, f, w, m};
  endfunction

  task automatic check_v(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_n(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check_v(e.req, {cpu, per, osc, rc, flt, wdt, mode}, e.v);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_o(string req, logic [7:0] v);
    sb_q.push_back('{req, v});
    @(negedge clk); #1;
  endtask

  task automatic do_reset(logic p);
    rst_ni = 1'b0; prot = p; hw_pd = 0; irq = 0;
    wr_arm = 0; wr_idle = 0; wr_pdn = 0; wr_slow = 0; slow_val = 0; wr_other = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    tick();
  endtask

  task automatic w_arm();   wr_arm = 1;   tick(); wr_arm = 0;   endtask
  task automatic w_idle();  wr_idle = 1;  tick(); wr_idle = 0;  endtask
  task automatic w_pdn();   wr_pdn = 1;   tick(); wr_pdn = 0;   endtask
  task automatic w_other(); wr_other = 1; tick(); wr_other = 0; endtask
  task automatic w_slow(logic v);
    wr_slow = 1; slow_val = v; tick(); wr_slow = 0; slow_val = 0;
  endtask
  task automatic pulse_irq(); irq = 1; tick(); irq = 0; endtask

  task automatic count_per(output int n);
    n = 0;
    repeat (16) begin
      @(negedge clk);
      if (per) n++;
    end
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset(1'b1);
    expect_o("R1 reset state", ev(1, 1, 1, 0, 1, 2'd0));
    prot = 0; tick(); tick(); tick();
    expect_o("R2 wdt kept after prot low", ev(1, 1, 1, 0, 1, 2'd0));

    w_arm(); w_idle();
    expect_o("R4 idle entry", ev(0, 1, 1, 0, 1, 2'd1));
    pulse_irq();
    expect_o("R5 irq wakes idle", ev(1, 1, 1, 0, 1, 2'd0));

    w_arm(); w_other(); w_idle();
    expect_o("R7 other write cancels arming", ev(1, 1, 1, 0, 1, 2'd0));
    w_idle();
    expect_o("R7 unarmed idle write", ev(1, 1, 1, 0, 1, 2'd0));
    w_arm(); w_slow(1'b0); w_pdn();
    expect_o("R7 slow write cancels arming", ev(1, 1, 1, 0, 1, 2'd0));

    w_slow(1'b1);
    count_per(n); check_n("R3 slow rate 1 in 8", n, 2);
    w_slow(1'b0);
    count_per(n); check_n("R3 full rate restored", n, 16);

    prot = 1;
    w_slow(1'b1);
    count_per(n); check_n("R8 slow request blocked", n, 16);
    w_arm(); w_idle();
    expect_o("R8 idle request blocked", ev(1, 1, 1, 0, 1, 2'd0));
    w_arm(); w_pdn();
    expect_o("R8 pdn request blocked", ev(1, 1, 1, 0, 1, 2'd0));
    prot = 0;

    w_arm(); w_pdn();
    expect_o("R6 pdn entry", ev(0, 0, 0, 0, 1, 2'd2));
    pulse_irq();
    expect_o("R6 irq ignored in pdn", ev(0, 0, 0, 0, 1, 2'd2));

    do_reset(1'b0);
    expect_o("R1 reset exits pdn", ev(1, 1, 1, 0, 0, 2'd0));
    prot = 1; tick(); tick();
    expect_o("R2 wdt stays low after prot high", ev(1, 1, 1, 0, 0, 2'd0));

    hw_pd = 1; tick();
    expect_o("R9 hwpd with prot high", ev(0, 0, 0, 1, 0, 2'd3));
    hw_pd = 0; tick();
    expect_o("R9 hwpd release", ev(1, 1, 1, 0, 0, 2'd0));

    prot = 0;
    w_slow(1'b1);
    hw_pd = 1; tick();
    expect_o("R9 hwpd from slow", ev(0, 0, 0, 1, 0, 2'd3));
    hw_pd = 0; tick();
    count_per(n); check_n("R9 slow cleared on release", n, 16);

    w_arm(); w_pdn();
    hw_pd = 1; tick();
    expect_o("R9 hwpd from pdn", ev(0, 0, 0, 1, 0, 2'd3));
    hw_pd = 0; tick();
    expect_o("R9 release after pdn", ev(1, 1, 1, 0, 0, 2'd0));

    w_arm();
    wr_pdn = 1; hw_pd = 1; tick(); wr_pdn = 0;
    expect_o("R10 hwpd beats armed pdn", ev(0, 0, 0, 1, 0, 2'd3));
    hw_pd = 0; tick();
    expect_o("R10 clean return", ev(1, 1, 1, 0, 0, 2'd0));

    while (sb_q.size() != 0) @(negedge clk);
    #1;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule